// File: doc/BRIEF.md
# Configuration Transaction Controller

This block gives software a three-word register window for issuing read and write transactions to a small table of board settings. One word holds the transfer data. One holds the command: a start flag, a direction flag and packed routing fields. The third reports completion and error. The table holds six main-board oscillator frequencies, a parameterised set of daughter-board oscillator frequencies and a parameterised set of daughter-board voltage readings. It also answers one fixed main-board voltage.

A command write with the start flag set decodes the packed fields and checks that the target is legal. On a legal read the data word is loaded from the table. On a legal write the data word is stored into the table. The status word records completion, and records an error when the target is illegal. Two main-board function codes request a shutdown or a reboot, and each of these drives a one-cycle request pulse.

The register window is reached through a single-cycle write strobe with a word address. Read data is combinational from the address.

Top module: `cfg_txn_ctrl`

## Requirements
- R1: After reset the data, command and status words read 0. The main-board oscillators hold, at indices 0 to 5, 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000. Daughter-board oscillator i holds its reset parameter value.
- R2: Address 1 is the command word. Its fields are: bit 31 start, bit 30 direction (1 write, 0 read), bits 29:26 channel, bits 25:20 function, bits 17:16 site, bits 15:12 position and bits 11:0 device. It reads back as written, except that bits 31, 19 and 18 always read 0.
- R3: A command write with bit 31 set makes the status word (address 2) read 1 when the access is legal and 3 when it is not.
- R4: An access is illegal unless the channel is 0, the position is 0 and the site is 0 (main board) or 1 (daughter board).
- R5: Function 1 (oscillator) is legal for main-board device below 6 or daughter-board device below DB_OSC_N. A read loads the data word (address 0) with the entry. A write stores the data word into the entry.
- R6: Function 2 (voltage) is legal only as a read. Main-board device 0 returns 3300000, and daughter-board device i below DB_VSENS_N returns its parameter value.
- R7: Writes of functions 7, 8, 9 and 11 to main-board device 0 are legal. Function 8 raises shutdown_req and function 9 raises reboot_req, each for exactly the one cycle after the command write.
- R8: Writing the status word stores only data bits 1:0. The other bits read 0.
- R9: A failed read leaves the data word unchanged. A failed write leaves the table unchanged.
- R10: The result of a command is readable in the cycle after its write. A command write with bit 31 clear changes neither the status word, the data word nor the table.
- R11: Address 3 reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address: 0 data, 1 command, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
The bench builds the block with three daughter-board oscillators and two voltage sensors. With these values, the bounds on both daughter-board device comparisons fall at small indices that random device numbers from 0 to 7 hit often, on either side of each limit. The main-board limit of six is crossed by the same device range. Directed cases pin the exact boundary indices, the illegal channel, position and site values, and voltage writes.

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl #(
  parameter int DB_OSC_N = 2,
  parameter int DB_VSENS_N = 2,
  parameter logic [DB_OSC_N*32-1:0] DB_OSC_INIT = {32'd40000000, 32'd33333333},
  parameter logic [DB_VSENS_N*32-1:0] DB_VOLT = {32'd1000000, 32'd900000}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        shutdown_req,
  output logic        reboot_req
);
  localparam int MB_OSC_N = 6;
  localparam logic [31:0] CTRL_KEEP = 32'h7FF3_FFFF;
  localparam logic [31:0] MB_VOLT = 32'd3300000;

  function automatic logic [31:0] mb_init(input int i);
    return (i == 0) ? 32'd50000000 : (i == 1) ? 32'd23750000 : 32'd24000000;
  endfunction

  logic [31:0] data_q, ctrl_q;
  logic [1:0]  stat_q;
  logic [31:0] mb_osc [MB_OSC_N];
  logic [31:0] db_osc [DB_OSC_N];

  wire        ctrl_wr = bus_wr && (bus_addr == 2'd1);
  wire        start   = ctrl_wr && bus_wdata[31];
  wire        is_wr   = bus_wdata[30];
  wire [3:0]  chan    = bus_wdata[29:26];
  wire [5:0]  fn      = bus_wdata[25:20];
  wire [1:0]  site    = bus_wdata[17:16];
  wire [3:0]  pos     = bus_wdata[15:12];
  wire [11:0] dev     = bus_wdata[11:0];

  wire route_ok = (chan == 4'd0) && (pos == 4'd0) && !site[1];
  wire on_mb    = (site == 2'd0);
  wire on_db    = (site == 2'd1);
  wire mb_osc_hit = on_mb && (32'(dev) < MB_OSC_N);
  wire db_osc_hit = on_db && (32'(dev) < DB_OSC_N);
  wire db_v_hit   = on_db && (32'(dev) < DB_VSENS_N);
  wire mb_dev0    = on_mb && (dev == 12'd0);
  wire fn_osc  = (fn == 6'd1);
  wire fn_volt = (fn == 6'd2);
  wire fn_misc = (fn == 6'd7) || (fn == 6'd8) || (fn == 6'd9) || (fn == 6'd11);

  wire wr_ok = route_ok && ((fn_osc && (mb_osc_hit || db_osc_hit)) || (fn_misc && mb_dev0));
  wire rd_ok = route_ok && ((fn_osc && (mb_osc_hit || db_osc_hit)) || (fn_volt && (mb_dev0 || db_v_hit)));
  wire acc_ok = is_wr ? wr_ok : rd_ok;

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (fn_osc) begin
      for (int i = 0; i < MB_OSC_N; i++)
        if (on_mb && 32'(dev) == i) rd_val = mb_osc[i];
      for (int i = 0; i < DB_OSC_N; i++)
        if (on_db && 32'(dev) == i) rd_val = db_osc[i];
    end else begin
      if (on_mb) rd_val = MB_VOLT;
      for (int i = 0; i < DB_VSENS_N; i++)
        if (on_db && 32'(dev) == i) rd_val = DB_VOLT[i*32 +: 32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
      shutdown_req <= 1'b0;
      reboot_req <= 1'b0;
      for (int i = 0; i < MB_OSC_N; i++) mb_osc[i] <= mb_init(i);
      for (int i = 0; i < DB_OSC_N; i++) db_osc[i] <= DB_OSC_INIT[i*32 +: 32];
    end else begin
      shutdown_req <= start && is_wr && wr_ok && (fn == 6'd8);
      reboot_req   <= start && is_wr && wr_ok && (fn == 6'd9);
      if (bus_wr) begin
        case (bus_addr)
          2'd0: data_q <= bus_wdata;
          2'd1: begin
            ctrl_q <= bus_wdata & CTRL_KEEP;
            if (start) begin
              stat_q <= {!acc_ok, 1'b1};
              if (!is_wr && rd_ok) data_q <= rd_val;
              if (is_wr && wr_ok && fn_osc) begin
                for (int i = 0; i < MB_OSC_N; i++)
                  if (on_mb && 32'(dev) == i) mb_osc[i] <= data_q;
                for (int i = 0; i < DB_OSC_N; i++)
                  if (on_db && 32'(dev) == i) db_osc[i] <= data_q;
              end
            end
          end
          2'd2: stat_q <= bus_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = data_q;
      2'd1:    bus_rdata = ctrl_q;
      2'd2:    bus_rdata = {30'd0, stat_q};
      default: bus_rdata = '0;
    endcase
  end

  AST_START_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> stat_q[0]); // R3
  AST_CTRL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_q[31] == 1'b0) && (ctrl_q[19:18] == 2'b00)); // R2
  AST_BAD_ROUTE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !route_ok) |=> stat_q == 2'b11); // R4
  AST_FAILED_READ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !is_wr && !rd_ok) |=> data_q == $past(data_q)); // R9
  AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(start && is_wr && route_ok && mb_dev0 && fn == 6'd8)); // R7
  AST_REBOOT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |-> $past(start && is_wr && route_ok && mb_dev0 && fn == 6'd9)); // R7
  AST_NO_START_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[31]) |=> $stable(stat_q)); // R10
  AST_STAT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2) |-> bus_rdata[31:2] == 30'd0); // R8
endmodule

// File: tb/cfg_txn_ctrl_tb_top.sv
module cfg_txn_ctrl_tb_top;
  localparam int NO = 3;
  localparam int NV = 2;
  localparam logic [NO*32-1:0] OINIT = {32'd12000000, 32'd25000000, 32'd60000000};
  localparam logic [NV*32-1:0] VINIT = {32'd1800000, 32'd950000};

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic shutdown_req, reboot_req;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  cfg_txn_ctrl #(.DB_OSC_N(NO), .DB_VSENS_N(NV), .DB_OSC_INIT(OINIT), .DB_VOLT(VINIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .shutdown_req(shutdown_req), .reboot_req(reboot_req));

  logic [31:0] m_mb [6];
  logic [31:0] m_db [NO];
  logic [31:0] m_data, m_ctrl;
  logic [1:0]  m_stat;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic chk_regs(input string tag);
    logic [31:0] v;
    rd(2'd0, v); chk({tag, " data"}, v, m_data);
    rd(2'd1, v); chk({tag, " ctrl R2"}, v, m_ctrl);
    rd(2'd2, v); chk({tag, " stat"}, v, {30'd0, m_stat});
  endtask

  function automatic logic [31:0] volt_of(input logic site0, input int dev);
    if (site0) return 32'd3300000;
    return VINIT[dev*32 +: 32];
  endfunction

  task automatic do_cmd(input logic [31:0] w);
    logic wd, ok, exp_sd, exp_rb, route, mb, db;
    logic [5:0] fn; int dev;
    logic [31:0] v;
    wd = w[30]; fn = w[25:20]; dev = int'(w[11:0]);
    mb = (w[17:16] == 0); db = (w[17:16] == 1);
    route = (w[29:26] == 0) && (w[15:12] == 0) && (mb || db);
    exp_sd = 0; exp_rb = 0;
    m_ctrl = w & 32'h7FF3_FFFF;
    if (w[31]) begin
      if (wd)
        ok = route && ((fn == 1 && ((mb && dev < 6) || (db && dev < NO))) ||
             ((fn == 7 || fn == 8 || fn == 9 || fn == 11) && mb && dev == 0));
      else
        ok = route && ((fn == 1 && ((mb && dev < 6) || (db && dev < NO))) ||
             (fn == 2 && ((mb && dev == 0) || (db && dev < NV))));
      m_stat = ok ? 2'b01 : 2'b11;
      if (ok && wd && fn == 1) begin
        if (mb) m_mb[dev] = m_data; else m_db[dev] = m_data;
      end
      if (ok && !wd) begin
        if (fn == 1) m_data = mb ? m_mb[dev] : m_db[dev];
        else m_data = volt_of(mb, dev);
      end
      exp_sd = ok && wd && fn == 8;
      exp_rb = ok && wd && fn == 9;
    end
    wr(2'd1, w);
    chk("shutdown pulse R7", {31'd0, shutdown_req}, {31'd0, exp_sd});
    chk("reboot pulse R7", {31'd0, reboot_req}, {31'd0, exp_rb});
    chk_regs("cmd R3 R5 R6 R9 R10");
    @(negedge clk);
    chk("pulse width R7", {30'd0, shutdown_req, reboot_req}, 32'd0);
    rd(2'd0, v);
  endtask

  function automatic logic [31:0] mk(input logic st, input logic w_, input int ch, input int f,
                                     input int s, input int p, input int d);
    return {st, w_, 4'(ch), 6'(f), 2'b00, 2'(s), 4'(p), 12'(d)};
  endfunction

  task automatic set_data(input logic [31:0] d);
    wr(2'd0, d); m_data = d;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_data = 0; m_ctrl = 0; m_stat = 0;
    for (int i = 0; i < 6; i++) m_mb[i] = (i == 0) ? 32'd50000000 : (i == 1) ? 32'd23750000 : 32'd24000000;
    for (int i = 0; i < NO; i++) m_db[i] = OINIT[i*32 +: 32];
    chk_regs("reset R1");
    for (int i = 0; i < 6; i++) do_cmd(mk(1, 0, 0, 1, 0, 0, i));   // R1 main oscillators
    for (int i = 0; i < NO; i++) do_cmd(mk(1, 0, 0, 1, 1, 0, i));  // R1 daughter oscillators
    // R5 boundary indices
    set_data(32'h1234_5678); do_cmd(mk(1, 1, 0, 1, 0, 0, 5)); do_cmd(mk(1, 0, 0, 1, 0, 0, 5));
    set_data(32'hCAFE_0001); do_cmd(mk(1, 1, 0, 1, 0, 0, 6));
    set_data(32'h0BAD_F00D); do_cmd(mk(1, 1, 0, 1, 1, 0, NO - 1)); do_cmd(mk(1, 0, 0, 1, 1, 0, NO - 1));
    do_cmd(mk(1, 0, 0, 1, 1, 0, NO));                              // R9 failed read
    // R6 voltage
    do_cmd(mk(1, 0, 0, 2, 0, 0, 0)); do_cmd(mk(1, 0, 0, 2, 1, 0, NV - 1));
    do_cmd(mk(1, 0, 0, 2, 1, 0, NV)); do_cmd(mk(1, 1, 0, 2, 0, 0, 0));
    // R4 routing
    do_cmd(mk(1, 0, 1, 1, 0, 0, 0)); do_cmd(mk(1, 0, 0, 1, 0, 1, 0)); do_cmd(mk(1, 0, 0, 1, 2, 0, 0));
    // R7 misc functions
    do_cmd(mk(1, 1, 0, 8, 0, 0, 0)); do_cmd(mk(1, 1, 0, 9, 0, 0, 0));
    do_cmd(mk(1, 1, 0, 7, 0, 0, 0)); do_cmd(mk(1, 1, 0, 11, 0, 0, 0));
    do_cmd(mk(1, 1, 0, 8, 0, 0, 1)); do_cmd(mk(1, 1, 0, 9, 1, 0, 0));
    // R10 no start; R2 masked bits
    do_cmd(mk(0, 1, 0, 1, 0, 0, 0) | 32'h000C_0000);
    // R8 status write
    wr(2'd2, 32'hFFFF_FFFF); m_stat = 2'b11; chk_regs("stat write R8");
    wr(2'd2, 32'hFFFF_FFFC); m_stat = 2'b00; chk_regs("stat write R8");
    // R11 unused address
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("addr3 R11", v, 32'd0); chk_regs("addr3 R11");
    void'($urandom(32'd20240611));
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      int fsel; int fl [8] = '{1, 1, 1, 2, 2, 7, 8, 9};
      if ($urandom % 2) set_data($urandom);
      fsel = $urandom % 10;
      w = mk(($urandom % 8) != 0, $urandom % 2,
             (($urandom % 8) == 0) ? 1 + $urandom % 15 : 0,
             (fsel < 8) ? fl[fsel] : $urandom % 64,
             (($urandom % 4) == 0) ? $urandom % 4 : $urandom % 2,
             (($urandom % 8) == 0) ? 1 + $urandom % 15 : 0,
             $urandom % 8);
      w[19:18] = 2'($urandom);
      do_cmd(w);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule